// File: doc/BRIEF.md
# ECC DIMM Half Resolver

When a memory error has been traced to a chip-select, this block works out which DIMM of that chip-select holds the failing location. A chip-select drives either one DIMM or, when the controller runs a 128-bit wide data path, a pair made of a lower-channel and an upper-channel DIMM. With a pair, the answer depends on the error-correction scheme in use. In the per-word 64/8 scheme each half of the data path is checked on its own, so the address alone is enough. In the symbol-based scheme the answer comes from where the decoded symbol sits, or from neither DIMM alone when the error cannot be corrected.

Requests come in on a valid/ready stream. Each request carries the DIMM presence flags, address bit 3 of the failing address, the ECC scheme, a correctable flag and the fields of the already-decoded symbol. Results leave on a second valid/ready stream as a two-bit DIMM mask and a two-bit error code. The result stage is one register deep. The input is ready when that register is empty or is being drained in the same cycle, so back-pressure on the output passes straight to the input. An accepted request shows up as a result in the next cycle. A result stays on the output, unchanged, until `out_ready` is high.

Top module: `ddr_half_resolver`

## Requirements
- R1: With both presence flags clear (`in_present` = 2'b00), the result has error code 2'b01 (no DIMM) and mask 2'b00.
- R2: With exactly one presence flag set, the result is mask 2'b01 (the first DIMM) and error code 2'b00, whatever the scheme, address bit and symbol fields are.
- R3: With both DIMMs present and the 64/8 scheme (`in_mode` = 0), `in_addr_b3` = 1 gives mask 2'b10 (upper DIMM) and `in_addr_b3` = 0 gives mask 2'b01 (lower DIMM), with error code 2'b00.
- R4: With both DIMMs present, the symbol scheme (`in_mode` = 1), a correctable error and a decodable symbol, the mask is 2'b01 in two cases: a data symbol (`in_sym_check` = 0) whose high bit index is 63 or less, or a check symbol (`in_sym_check` = 1) whose high bit index is 7 or less. Every other symbol gives mask 2'b10.
- R5: With both DIMMs present, the symbol scheme and an uncorrectable error, the mask is 2'b11 and the error code is 2'b00. In this case `in_sym_bad` and the symbol fields have no effect.
- R6: With both DIMMs present, the symbol scheme, a correctable error and `in_sym_bad` = 1, the error code is 2'b10 (syndrome invalid) and the mask is 2'b00.
- R7: Each request accepted on the input (`in_valid` and `in_ready` high at a clock edge) produces exactly one result. That result has `out_valid` high from the next edge on. Results keep the order of the requests.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and at the next edge `out_valid` stays high with `out_mask` and `out_err` unchanged.
- R9: After reset, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle when high with in_valid |
| in_present | input | 2 | DIMM presence: bit 0 first (lower) slot, bit 1 second (upper) slot |
| in_addr_b3 | input | 1 | Bit 3 of the failing physical address |
| in_mode | input | 1 | ECC scheme: 0 = 64/8 per word, 1 = symbol based |
| in_correctable | input | 1 | Error is correctable |
| in_sym_bad | input | 1 | Decoded symbol fields are unusable |
| in_sym_check | input | 1 | Symbol covers check bits (1) or data bits (0) |
| in_sym_hibit | input | HIBIT_W | Highest bit index covered by the symbol |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_mask | output | 2 | DIMM mask: bit 0 first DIMM, bit 1 second DIMM |
| out_err | output | 2 | 0 none, 1 no DIMM, 2 syndrome invalid |

## Verification
The properties assume that the request fields are meaningful whenever `in_valid` is high and that reset is applied for at least one edge before traffic starts. They also read the request fields only at the edge where a request is accepted. The stimulus holds every request field steady from the moment `in_valid` rises until the handshake completes. Fields change only after a negative clock edge. Phases with random `out_ready` stalls keep the properties about holding results and returning back-pressure busy.

// File: rtl/ddr_half_pkg.sv
package ddr_half_pkg;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_NO_DIMM = 2'd1,
    ERR_SYND    = 2'd2
  } err_e;

  typedef enum logic [1:0] {
    POP_NONE = 2'd0,
    POP_ONE  = 2'd1,
    POP_TWO  = 2'd2
  } pop_e;

  typedef enum logic {
    MODE_WORD   = 1'b0,
    MODE_SYMBOL = 1'b1
  } ecc_mode_e;

  typedef struct packed {
    logic [1:0] mask;
    err_e       err;
  } result_t;

  localparam logic [1:0] MASK_LO   = 2'b01;
  localparam logic [1:0] MASK_HI   = 2'b10;
  localparam logic [1:0] MASK_BOTH = 2'b11;

endpackage

// File: rtl/ddr_half_pop.sv
module ddr_half_pop
  import ddr_half_pkg::*;
#(
  parameter int NSLOT = 2
) (
  input  logic [NSLOT-1:0] present,
  output pop_e             pop
);
  localparam int CNT_W = $clog2(NSLOT + 1);

  logic [CNT_W-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NSLOT; i++) begin
      cnt = cnt + CNT_W'(present[i]);
    end
  end

  always_comb begin
    if (cnt == CNT_W'(0))      pop = POP_NONE;
    else if (cnt == CNT_W'(1)) pop = POP_ONE;
    else                       pop = POP_TWO;
  end
endmodule

// File: rtl/ddr_half_sym.sv
module ddr_half_sym #(
  parameter int HIBIT_W      = 7,
  parameter int DATA_HI_MAX  = 63,
  parameter int CHECK_HI_MAX = 7
) (
  input  logic               is_check,
  input  logic [HIBIT_W-1:0] hibit,
  output logic               lower
);
  localparam logic [HIBIT_W-1:0] DATA_LIM  = HIBIT_W'(DATA_HI_MAX);
  localparam logic [HIBIT_W-1:0] CHECK_LIM = HIBIT_W'(CHECK_HI_MAX);

  logic data_low, check_low;

  assign data_low  = (hibit <= DATA_LIM);
  assign check_low = (hibit <= CHECK_LIM);
  assign lower     = is_check ? check_low : data_low;
endmodule

// File: rtl/ddr_half_pick.sv
module ddr_half_pick
  import ddr_half_pkg::*;
(
  input  pop_e      pop,
  input  ecc_mode_e mode,
  input  logic      addr_b3,
  input  logic      correctable,
  input  logic      sym_bad,
  input  logic      sym_lower,
  output result_t   res
);
  always_comb begin
    res.mask = 2'b00;
    res.err  = ERR_NONE;
    case (pop)
      POP_NONE: res.err  = ERR_NO_DIMM;
      POP_ONE:  res.mask = MASK_LO;
      default: begin
        if (mode == MODE_WORD) begin
          res.mask = addr_b3 ? MASK_HI : MASK_LO;
        end else if (!correctable) begin
          res.mask = MASK_BOTH;
        end else if (sym_bad) begin
          res.err  = ERR_SYND;
        end else begin
          res.mask = sym_lower ? MASK_LO : MASK_HI;
        end
      end
    endcase
  end
endmodule

// File: rtl/ddr_half_oreg.sv
module ddr_half_oreg
  import ddr_half_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    in_valid,
  output logic    in_ready,
  input  result_t in_res,
  output logic    out_valid,
  input  logic    out_ready,
  output result_t out_res
);
  logic    vld_q;
  result_t res_q;

  assign in_ready = !vld_q || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q      <= 1'b0;
      res_q.mask <= 2'b00;
      res_q.err  <= ERR_NONE;
    end else if (in_ready) begin
      vld_q <= in_valid;
      if (in_valid) res_q <= in_res;
    end
  end

  assign out_valid = vld_q;
  assign out_res   = res_q;
endmodule

// File: rtl/ddr_half_resolver.sv
module ddr_half_resolver
  import ddr_half_pkg::*;
#(
  parameter int HIBIT_W      = 7,
  parameter int DATA_HI_MAX  = 63,
  parameter int CHECK_HI_MAX = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [1:0]         in_present,
  input  logic               in_addr_b3,
  input  logic               in_mode,
  input  logic               in_correctable,
  input  logic               in_sym_bad,
  input  logic               in_sym_check,
  input  logic [HIBIT_W-1:0] in_sym_hibit,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [1:0]         out_mask,
  output logic [1:0]         out_err
);
  localparam int NSLOT = 2;

  pop_e    pop;
  logic    sym_lower;
  result_t comb_res;
  result_t reg_res;

  ddr_half_pop #(.NSLOT(NSLOT)) u_pop (
    .present (in_present),
    .pop     (pop)
  );

  ddr_half_sym #(
    .HIBIT_W      (HIBIT_W),
    .DATA_HI_MAX  (DATA_HI_MAX),
    .CHECK_HI_MAX (CHECK_HI_MAX)
  ) u_sym (
    .is_check (in_sym_check),
    .hibit    (in_sym_hibit),
    .lower    (sym_lower)
  );

  ddr_half_pick u_pick (
    .pop         (pop),
    .mode        (ecc_mode_e'(in_mode)),
    .addr_b3     (in_addr_b3),
    .correctable (in_correctable),
    .sym_bad     (in_sym_bad),
    .sym_lower   (sym_lower),
    .res         (comb_res)
  );

  ddr_half_oreg u_oreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_res    (comb_res),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_res   (reg_res)
  );

  assign out_mask = reg_res.mask;
  assign out_err  = reg_res.err;
endmodule

// File: rtl/ddr_half_resolver_chk.sv
module ddr_half_resolver_chk #(
  parameter int HIBIT_W      = 7,
  parameter int DATA_HI_MAX  = 63,
  parameter int CHECK_HI_MAX = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [1:0]         in_present,
  input logic               in_addr_b3,
  input logic               in_mode,
  input logic               in_correctable,
  input logic               in_sym_bad,
  input logic               in_sym_check,
  input logic [HIBIT_W-1:0] in_sym_hibit,
  input logic               out_valid,
  input logic               out_ready,
  input logic [1:0]         out_mask,
  input logic [1:0]         out_err
);
  logic fire, pair, sym_low;
  assign fire    = in_valid && in_ready;
  assign pair    = (in_present == 2'b11);
  assign sym_low = in_sym_check ? (in_sym_hibit <= HIBIT_W'(CHECK_HI_MAX))
                                : (in_sym_hibit <= HIBIT_W'(DATA_HI_MAX));

  // R1
  no_dimm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_present == 2'b00 |=> out_err == 2'b01 && out_mask == 2'b00);

  // R2
  single_dimm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && $countones(in_present) == 1 |=> out_mask == 2'b01 && out_err == 2'b00);

  // R3
  word_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && pair && !in_mode |=> out_mask == ($past(in_addr_b3) ? 2'b10 : 2'b01));

  // R4
  sym_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && pair && in_mode && in_correctable && !in_sym_bad
      |=> out_mask == ($past(sym_low) ? 2'b01 : 2'b10) && out_err == 2'b00);

  // R5
  both_dimm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && pair && in_mode && !in_correctable |=> out_mask == 2'b11 && out_err == 2'b00);

  // R6
  synd_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && pair && in_mode && in_correctable && in_sym_bad
      |=> out_err == 2'b10 && out_mask == 2'b00);

  // R7
  accept_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  // R8
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_mask) && $stable(out_err));

  // R8
  backpress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R9
  reset_idle_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> !out_valid);
endmodule

bind ddr_half_resolver ddr_half_resolver_chk #(
  .HIBIT_W      (HIBIT_W),
  .DATA_HI_MAX  (DATA_HI_MAX),
  .CHECK_HI_MAX (CHECK_HI_MAX)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_valid       (in_valid),
  .in_ready       (in_ready),
  .in_present     (in_present),
  .in_addr_b3     (in_addr_b3),
  .in_mode        (in_mode),
  .in_correctable (in_correctable),
  .in_sym_bad     (in_sym_bad),
  .in_sym_check   (in_sym_check),
  .in_sym_hibit   (in_sym_hibit),
  .out_valid      (out_valid),
  .out_ready      (out_ready),
  .out_mask       (out_mask),
  .out_err        (out_err)
);

// File: tb/ddr_half_resolver_test.sv
`timescale 1ns/1ps
module ddr_half_resolver_test;
  localparam int HW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [1:0]    in_present = 2'b00;
  logic          in_addr_b3 = 1'b0;
  logic          in_mode = 1'b0;
  logic          in_correctable = 1'b0;
  logic          in_sym_bad = 1'b0;
  logic          in_sym_check = 1'b0;
  logic [HW-1:0] in_sym_hibit = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [1:0]    out_mask;
  logic [1:0]    out_err;

  int checks = 0;
  int fails = 0;
  int sent = 0;
  int got = 0;
  bit stall_en = 1'b0;
  bit done = 1'b0;
  logic [3:0] expq[$];
  string      tagq[$];

  always #10 clk = ~clk;

  ddr_half_resolver uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_present(in_present), .in_addr_b3(in_addr_b3), .in_mode(in_mode),
    .in_correctable(in_correctable), .in_sym_bad(in_sym_bad),
    .in_sym_check(in_sym_check), .in_sym_hibit(in_sym_hibit),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_mask(out_mask), .out_err(out_err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // expected {mask, err} from the requirements
  task automatic model(input logic [1:0] pres, input logic b3, input logic md,
                       input logic corr, input logic bad, input logic chk,
                       input logic [HW-1:0] hb, output logic [3:0] r, output string tag);
    bit low;
    low = chk ? (hb <= 7) : (hb <= 63);
    if (pres == 2'b00)            begin r = {2'b00, 2'b01}; tag = "R1"; end
    else if (pres != 2'b11)       begin r = {2'b01, 2'b00}; tag = "R2"; end
    else if (!md)                 begin r = {b3 ? 2'b10 : 2'b01, 2'b00}; tag = "R3"; end
    else if (!corr)               begin r = {2'b11, 2'b00}; tag = "R5"; end
    else if (bad)                 begin r = {2'b00, 2'b10}; tag = "R6"; end
    else                          begin r = {low ? 2'b01 : 2'b10, 2'b00}; tag = "R4"; end
  endtask

  task automatic send(input logic [1:0] pres, input logic b3, input logic md,
                      input logic corr, input logic bad, input logic chk,
                      input logic [HW-1:0] hb);
    logic [3:0] e;
    string t;
    model(pres, b3, md, corr, bad, chk, hb, e, t);
    @(negedge clk);
    in_present = pres; in_addr_b3 = b3; in_mode = md; in_correctable = corr;
    in_sym_bad = bad; in_sym_check = chk; in_sym_hibit = hb; in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    expq.push_back(e);
    tagq.push_back(t);
    sent++;
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // out_ready driver
  initial begin
    logic [31:0] rs;
    rs = 32'h1234_5678;
    forever begin
      @(posedge clk);
      #2;
      rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
      out_ready = stall_en ? rs[4] : 1'b1;
    end
  end

  // monitor / scoreboard
  initial begin
    bit         held;
    logic [1:0] hm, he;
    held = 1'b0; hm = '0; he = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (held) check(out_valid && out_mask == hm && out_err == he, "R8 hold",
                        {out_valid, out_mask, out_err}, {1'b1, hm, he});
        if (out_valid && !out_ready)
          check(!in_ready, "R8 in_ready", in_ready, 0);
        held = out_valid && !out_ready;
        hm = out_mask; he = out_err;
        if (out_valid && out_ready) begin
          got++;
          if (expq.size() == 0) begin
            check(1'b0, "R7 unexpected result", {out_mask, out_err}, 0);
          end else begin
            logic [3:0] e;
            string t;
            e = expq.pop_front();
            t = tagq.pop_front();
            check({out_mask, out_err} == e, t, {out_mask, out_err}, e);
          end
        end
      end
    end
  end

  initial begin
    #(20 * 150000);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [31:0] r;
    r = 32'hACE1_0F0F;
    repeat (3) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R9 reset", out_valid, 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R9 after reset", out_valid, 0);

    // R1 no DIMM
    send(2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 7'd3);
    // R2 single DIMM, either slot, unaffected by other fields
    send(2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 7'd0);
    send(2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 7'd100);
    // R3 word mode
    send(2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 7'd99);
    send(2'b11, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 7'd0);
    // R4 boundaries
    send(2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 7'd63);
    send(2'b11, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 7'd64);
    send(2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 7'd7);
    send(2'b11, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 7'd8);
    // R5 uncorrectable, bad flag ignored
    send(2'b11, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 7'd10);
    send(2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 7'd120);
    // R6 syndrome invalid
    send(2'b11, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 7'd5);

    // random traffic with output stalls (R7, R8)
    stall_en = 1'b1;
    for (int i = 0; i < 400; i++) begin
      r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
      send(r[1:0], r[2], r[3], r[4], r[5] & r[6], r[7], r[14:8]);
    end
    stall_en = 1'b0;

    for (int i = 0; i < 50 && expq.size() != 0; i++) @(negedge clk);
    check(expq.size() == 0 && got == sent, "R7 count", got, sent);
    @(negedge clk);
    check(out_valid == 1'b0, "R7 no extra result", out_valid, 0);
    finish_run();
  end
endmodule